// File: doc/BRIEF.md
# Programmable Digital Input Glitch Filter

This block cleans up one asynchronous digital input before it reaches edge-detection logic. The raw pin is first brought into the system clock domain through a short chain of flip-flops. A filtered level is kept alongside it. When the synchronized level disagrees with the filtered level, a small up counter advances on each filter tick. The new level is accepted only after it has held steady for a programmed number of ticks. If the input goes back to the accepted level before that point, the counter is cleared. Pulses shorter than the programmed window therefore never reach the output.

The window is chosen by a 4-bit select, normally one-hot. The ticks come either from every system clock cycle or from an external tick-enable pulse supplied by a prescaler elsewhere. All state sits in the single system clock domain. Freeze or time-base enables do not stop the filter.

Top module: `glf_top`

## Requirements
- R1: While `rst` is high at a clock edge, the filtered output, the synchronizer stages and the counter clear to 0. After reset `filt_out` reads 0.
- R2: `raw_in` passes through two system-clock flip-flops before filtering. With `width_sel` = 4'b0000 the filter is bypassed, and a level change on `raw_in` appears on `filt_out` three clock edges after it is first sampled.
- R3: With `clk_sel` = 0, a tick occurs every cycle. The number of stable ticks N needed is set by `width_sel`: bit0 gives 2, bit1 gives 4, bit2 gives 8 and bit3 gives 16. A lasting level change on `raw_in` reaches `filt_out` exactly 2+N clock edges after it is first sampled.
- R4: A pulse on `raw_in` lasting fewer than N ticks never changes `filt_out`. A pulse lasting exactly N ticks is accepted.
- R5: Any return of the synchronized input to the filtered level before acceptance clears the counter. Two sub-window pulses separated by a one-cycle reversal are rejected, even when their combined length exceeds N.
- R6: Filtering applies to both directions. Falling transitions obey the same window and glitch rejection as rising ones.
- R7: With `clk_sel` = 1, the counter advances only in cycles where `tick_in` is high. With `tick_in` held low, `filt_out` never changes while filtering is enabled. The new level is accepted on the N-th tick pulse.
- R8: If more than one bit of `width_sel` is set, the highest set bit chooses N.
- R9: If the window shrinks while a count is under way, a count already at or past the new limit accepts the level on the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 1 | Asynchronous raw input level |
| width_sel | input | 4 | Filter window select; 0000 bypasses the filter |
| clk_sel | input | 1 | Tick source: 0 = every cycle, 1 = `tick_in` |
| tick_in | input | 1 | External prescaled tick enable |
| filt_out | output | 1 | Validated filtered level |

## Verification
A wrong count shows up directly as a shifted acceptance edge on `filt_out`. The latency checks in every window setting catch an off-by-one within 2+N cycles of a change. A counter that fails to clear on a reversal lets the split-pulse pattern through, which is visible within one window after the second half. A wrong tick source either passes an edge while `tick_in` is held low or stays stuck after the N-th pulse. Both are observed within a few cycles.

// File: rtl/glf_pkg.sv
package glf_pkg;
    localparam int SEL_W  = 4;
    localparam int CNT_W  = 5;
    localparam int SYNC_N = 2;

    typedef enum logic {
        TICK_SYSCLK = 1'b0,
        TICK_EXT    = 1'b1
    } tick_src_e;

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } filt_state_t;

    // Highest set select bit i gives a window of 2^(i+1) ticks; returns
    // the last count value before acceptance (window minus one).
    function automatic logic [CNT_W-1:0] limit_of(input logic [SEL_W-1:0] sel);
        logic [CNT_W-1:0] lim;
        lim = '0;
        for (int i = 0; i < SEL_W; i++) begin
            if (sel[i]) lim = CNT_W'((1 << (i + 1)) - 1);
        end
        return lim;
    endfunction
endpackage

// File: rtl/glf_sync.sv
module glf_sync #(
    parameter int STAGES = glf_pkg::SYNC_N
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else if (g == 0) chain_q[g] <= d_in;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/glf_tick_gen.sv
module glf_tick_gen
    import glf_pkg::*;
(
    input  tick_src_e src,
    input  logic      ext_tick,
    output logic      tick_en
);
    always_comb begin
        unique case (src)
            TICK_SYSCLK: tick_en = 1'b1;
            TICK_EXT:    tick_en = ext_tick;
            default:     tick_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/glf_core.sv
module glf_core
    import glf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_lvl,
    input  logic             tick_en,
    input  logic             bypass,
    input  logic [CNT_W-1:0] limit,
    output logic             lvl_out
);
    filt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (bypass) begin
            st_d.lvl = sync_lvl;
            st_d.cnt = '0;
        end else if (sync_lvl == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (tick_en) begin
            if (st_q.cnt >= limit) begin
                st_d.lvl = sync_lvl;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign lvl_out = st_q.lvl;

    // Filtered level holds when filtering and no tick arrives.
    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !tick_en) |=> $stable(st_q.lvl));

    // A reversal to the accepted level clears the count.
    p_clear_on_match_r5: assert property (@(posedge clk) disable iff (rst)
        (sync_lvl == st_q.lvl) |=> (st_q.cnt == '0));

    // The output only ever takes the synchronized level.
    p_out_from_sync_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.lvl) |-> (st_q.lvl == $past(sync_lvl)));

    // Bypass copies the synchronized level in one cycle.
    p_bypass_copy_r2: assert property (@(posedge clk) disable iff (rst)
        bypass |=> (st_q.lvl == $past(sync_lvl)));

    // The counter never runs past the largest window.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt <= CNT_W'(15)));
endmodule

// File: rtl/glf_top.sv
module glf_top
    import glf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_in,
    input  logic [SEL_W-1:0] width_sel,
    input  logic             clk_sel,
    input  logic             tick_in,
    output logic             filt_out
);
    logic             sync_lvl;
    logic             tick_en;
    logic [CNT_W-1:0] limit;
    logic             bypass;
    tick_src_e        src;

    assign src    = tick_src_e'(clk_sel);
    assign bypass = (width_sel == '0);
    assign limit  = limit_of(width_sel);

    glf_sync #(.STAGES(SYNC_N)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (raw_in),
        .q_out (sync_lvl)
    );

    glf_tick_gen u_tick (
        .src      (src),
        .ext_tick (tick_in),
        .tick_en  (tick_en)
    );

    glf_core u_core (
        .clk      (clk),
        .rst      (rst),
        .sync_lvl (sync_lvl),
        .tick_en  (tick_en),
        .bypass   (bypass),
        .limit    (limit),
        .lvl_out  (filt_out)
    );

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !filt_out);
endmodule

// File: tb/glf_top_tb_top.sv
module glf_top_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       raw_in;
    logic [3:0] width_sel;
    logic       clk_sel;
    logic       tick_in;
    logic       filt_out;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    glf_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .raw_in    (raw_in),
        .width_sel (width_sel),
        .clk_sel   (clk_sel),
        .tick_in   (tick_in),
        .filt_out  (filt_out)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input logic lvl);
        @(negedge clk);
        clk_sel = 1'b0; tick_in = 1'b0; width_sel = 4'b0001; raw_in = lvl;
        repeat (40) @(negedge clk);
    endtask

    // Returns negedges after the change until filt_out shows the new level.
    task automatic latency(input logic [3:0] sel, input logic lvl, input string req, input int exp);
        int lat;
        settle(~lvl);
        width_sel = sel;
        @(negedge clk);
        raw_in = lvl;
        lat = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (lat == 0 && filt_out == lvl) lat = i;
        end
        check(req, lat, exp);
    endtask

    // Pulse away from base level for len cycles; reports whether it passed.
    task automatic pulse(input logic [3:0] sel, input logic base, input int len,
                         input string req, input int exp_pass);
        int seen;
        settle(base);
        width_sel = sel;
        @(negedge clk);
        raw_in = ~base;
        repeat (len) @(negedge clk);
        raw_in = base;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (filt_out != base) seen = 1;
            @(negedge clk);
        end
        check(req, seen, exp_pass);
    endtask

    task automatic t_reset;
        raw_in = 1'b1; width_sel = 4'b0000; clk_sel = 1'b0; tick_in = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 output after reset", int'(filt_out), 0);
        rst = 1'b0;
        raw_in = 1'b0;
        repeat (5) @(negedge clk);
        check("R1 output stays low", int'(filt_out), 0);
    endtask

    task automatic t_split;
        int seen;
        settle(1'b0);
        width_sel = 4'b0010;
        @(negedge clk);
        raw_in = 1'b1;
        repeat (3) @(negedge clk);
        raw_in = 1'b0;
        @(negedge clk);
        raw_in = 1'b1;
        repeat (3) @(negedge clk);
        raw_in = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (filt_out) seen = 1;
            @(negedge clk);
        end
        check("R5 split pulse rejected", seen, 0);
    endtask

    task automatic t_ext;
        settle(1'b0);
        width_sel = 4'b0001;
        clk_sel = 1'b1;
        tick_in = 1'b0;
        raw_in = 1'b1;
        repeat (50) @(negedge clk);
        check("R7 no tick holds output", int'(filt_out), 0);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 one tick not enough", int'(filt_out), 0);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        check("R7 second tick accepts", int'(filt_out), 1);
        clk_sel = 1'b0;
    endtask

    task automatic t_shrink;
        settle(1'b0);
        width_sel = 4'b1000;
        @(negedge clk);
        raw_in = 1'b1;
        repeat (10) @(negedge clk);
        check("R9 still filtering", int'(filt_out), 0);
        width_sel = 4'b0001;
        @(negedge clk);
        check("R9 shrunk window accepts", int'(filt_out), 1);
    endtask

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        latency(4'b0000, 1'b1, "R2 bypass latency", 3);
        latency(4'b0001, 1'b1, "R3 window 2", 4);
        latency(4'b0010, 1'b1, "R3 window 4", 6);
        latency(4'b0100, 1'b1, "R3 window 8", 10);
        latency(4'b1000, 1'b1, "R3 window 16", 18);
        pulse(4'b0010, 1'b0, 3, "R4 short pulse rejected", 0);
        pulse(4'b0010, 1'b0, 4, "R4 exact pulse accepted", 1);
        pulse(4'b1000, 1'b0, 15, "R4 long window glitch", 0);
        t_split();
        latency(4'b0100, 1'b0, "R6 falling latency", 10);
        pulse(4'b0100, 1'b1, 7, "R6 low glitch rejected", 0);
        pulse(4'b0100, 1'b1, 8, "R6 low pulse accepted", 1);
        t_ext();
        latency(4'b0110, 1'b1, "R8 highest bit wins", 10);
        latency(4'b1001, 1'b1, "R8 highest bit of two", 18);
        t_shrink();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule